// File: doc/BRIEF.md
# Prioritised Fault Duty-Cycle Indicator

This block drives one active-low fault pin with a fixed-rate pulse train whose duty cycle identifies the most serious fault class currently reported. Four fault-class flags come in from the detection logic. The block picks the most important active flag and shows it as a waveform. It uses a period of `PERIOD_TICKS` ticks of an enable strobe. With a 1 MHz strobe and the default period of 1000 ticks, the pin runs at 1 kHz.

Duty cycle is the fraction of each period during which the pin is high. The most serious class is shown as a steady low level. With no fault, the pin stays high.

The class on display is sampled only when the period counter wraps. Every period is therefore a complete, clean waveform of a single class, and flags that change part-way through a period wait for the next boundary.

Top module: `fault_duty_indicator`

## Requirements
- R1: While reset is asserted, and after its release until the first class is latched at a period boundary, the pin is high.
- R2: When no flag is set at a period boundary, the pin is high for the whole of the following period.
- R3: When the winning class at a boundary is flag bit 0 (gate-supply fault), the pin is high for the first 3/4 of the period's ticks and low for the rest.
- R4: When the winning class is flag bit 1 (source-supply or intermediate-rail fault), the pin is high for the first half of the period's ticks and low for the second half.
- R5: When the winning class is flag bit 2 (common-electrode buffer fault), the pin is high for the first quarter of the period's ticks and low for the rest.
- R6: When the winning class is flag bit 3 (memory fault or thermal shutdown), the pin is low for the whole period.
- R7: Priority is strict: bit 3 wins over bit 2, bit 2 wins over bit 1, and bit 1 wins over bit 0.
- R8: A period lasts exactly `PERIOD_TICKS` cycles in which the tick input is high, counted from reset release. Cycles without a tick advance nothing and leave the pin unchanged.
- R9: Flags are sampled only in the cycle where the last tick of a period occurs. Flag changes at any other time have no effect on the pin until that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one cycle wide per tick (1 MHz equivalent) |
| fault_i | input | 4 | Fault-class flags: bit 0 gate supply, bit 1 source/intermediate rail, bit 2 common-electrode buffer, bit 3 memory or thermal |
| fault_n_o | output | 1 | Active-low fault pin level |

## Verification
The assertions take for granted that `tick_i` and `fault_i` are already synchronous to `clk` and stable around each rising edge, and that `tick_i` is a level enable sampled once per cycle. The stimulus keeps within this by changing every input only on the falling edge. It drives ticks both on every cycle and in sparse patterns, so that the stalled cycles are exercised. It also toggles the flags in the middle of periods, so that the boundary sampling is tested against inputs that are deliberately out of phase with the counter.

// File: rtl/fdi_pkg.sv
package fdi_pkg;

   // Displayed class, ordered by rising priority
   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_GATE   = 3'd1,
      CLS_SRC    = 3'd2,
      CLS_BUF    = 3'd3,
      CLS_SEVERE = 3'd4
   } fdi_class_t;

   localparam int unsigned FDI_NUM_CLASSES = 4;

endpackage

// File: rtl/fdi_prio.sv
module fdi_prio
   import fdi_pkg::*;
#(
   parameter int unsigned N = FDI_NUM_CLASSES
) (
   input  logic [N-1:0] flags_i,
   output fdi_class_t   cls_o
);

   logic [N-1:0] win;

   generate
      if (N != FDI_NUM_CLASSES) begin : g_bad_n
         $error("fdi_prio: N must match the number of displayed classes");
      end
      for (genvar i = 0; i < N; i++) begin : g_win
         if (i == N - 1) begin : g_top
            assign win[i] = flags_i[i];
         end else begin : g_low
            assign win[i] = flags_i[i] & ~(|flags_i[N-1:i+1]);
         end
      end
   endgenerate

   always_comb begin
      cls_o = CLS_NONE;
      for (int k = 0; k < N; k++) begin
         if (win[k]) cls_o = fdi_class_t'(3'(k + 1));
      end
   end

endmodule

// File: rtl/fdi_period.sv
module fdi_period #(
   parameter int unsigned PERIOD = 1000,
   parameter int unsigned CW     = $clog2(PERIOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] cnt_nx_o,
   output logic          wrap_o
);

   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   generate
      if (PERIOD < 4 || (PERIOD % 4) != 0) begin : g_bad_period
         $error("fdi_period: PERIOD must be a multiple of 4, at least 4");
      end
   endgenerate

   assign wrap_o = tick_i && (cnt_o == LAST);

   always_comb begin
      if (!tick_i)     cnt_nx_o = cnt_o;
      else if (wrap_o) cnt_nx_o = '0;
      else             cnt_nx_o = cnt_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_nx_o;
   end

   assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= LAST);

   assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_o));

   assert_cnt_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_o == '0));

endmodule

// File: rtl/fdi_wave.sv
module fdi_wave
   import fdi_pkg::*;
#(
   parameter int unsigned PERIOD = 1000,
   parameter int unsigned CW     = $clog2(PERIOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          wrap_i,
   input  fdi_class_t    cls_i,
   input  logic [CW-1:0] cnt_nx_i,
   output logic          pin_o,
   output fdi_class_t    cls_q_o
);

   localparam logic [CW-1:0] HI_GATE = CW'((PERIOD * 3) / 4);
   localparam logic [CW-1:0] HI_SRC  = CW'(PERIOD / 2);
   localparam logic [CW-1:0] HI_BUF  = CW'(PERIOD / 4);

   fdi_class_t code_nx;
   logic       pin_nx;

   function automatic logic level(input fdi_class_t c, input logic [CW-1:0] n);
      case (c)
         CLS_NONE: level = 1'b1;
         CLS_GATE: level = (n < HI_GATE);
         CLS_SRC:  level = (n < HI_SRC);
         CLS_BUF:  level = (n < HI_BUF);
         default:  level = 1'b0;
      endcase
   endfunction

   assign code_nx = wrap_i ? cls_i : cls_q_o;
   assign pin_nx  = level(code_nx, cnt_nx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q_o <= CLS_NONE;
         pin_o   <= 1'b1;
      end else if (tick_i) begin
         cls_q_o <= code_nx;
         pin_o   <= pin_nx;
      end
   end

   assert_code_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> $stable(cls_q_o));

   assert_severe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_q_o == CLS_SEVERE) |-> !pin_o);

   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_q_o == CLS_NONE) |-> pin_o);

   assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(pin_o));

endmodule

// File: rtl/fault_duty_indicator.sv
module fault_duty_indicator
   import fdi_pkg::*;
#(
   parameter int unsigned PERIOD_TICKS = 1000,
   parameter int unsigned NUM_FLAGS    = FDI_NUM_CLASSES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic [NUM_FLAGS-1:0] fault_i,
   output logic                 fault_n_o
);

   localparam int unsigned CW = $clog2(PERIOD_TICKS);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nx;
   logic          wrap;
   fdi_class_t    cls_win;
   fdi_class_t    cls_shown;

   fdi_prio #(.N(NUM_FLAGS)) u_prio (
      .flags_i (fault_i),
      .cls_o   (cls_win)
   );

   fdi_period #(.PERIOD(PERIOD_TICKS), .CW(CW)) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .cnt_o    (cnt),
      .cnt_nx_o (cnt_nx),
      .wrap_o   (wrap)
   );

   fdi_wave #(.PERIOD(PERIOD_TICKS), .CW(CW)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .wrap_i   (wrap),
      .cls_i    (cls_win),
      .cnt_nx_i (cnt_nx),
      .pin_o    (fault_n_o),
      .cls_q_o  (cls_shown)
   );

   assert_top_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && fault_i[NUM_FLAGS-1]) |=> (!fault_n_o && cls_shown == CLS_SEVERE));

   assert_top_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && fault_i == '0) |=> fault_n_o);

   assert_top_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && fault_i == NUM_FLAGS'(1)) |=> (fault_n_o && cnt == '0));

endmodule

// File: tb/sim_fault_duty_indicator.sv
module sim_fault_duty_indicator;

   localparam int P = 20;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick  = 1'b0;
   logic [3:0] flt   = 4'b0000;
   logic       pin;

   always #2 clk = ~clk;

   fault_duty_indicator #(.PERIOD_TICKS(P)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .fault_i   (flt),
      .fault_n_o (pin)
   );

   typedef struct {
      logic  exp;
      string tag;
   } item_t;

   item_t sb[$];
   int    checks = 0;
   int    fails  = 0;
   int    mcnt   = 0;
   int    mcode  = 0;
   bit    done   = 0;

   // Class from flags per R7: bit3 > bit2 > bit1 > bit0
   function automatic int resolve(input logic [3:0] f);
      if (f[3])      return 4;
      else if (f[2]) return 3;
      else if (f[1]) return 2;
      else if (f[0]) return 1;
      return 0;
   endfunction

   // Pin level per R2..R6
   function automatic logic level(input int c, input int n);
      case (c)
         0: return 1'b1;
         1: return n < (P * 3) / 4;
         2: return n < P / 2;
         3: return n < P / 4;
         default: return 1'b0;
      endcase
   endfunction

   task automatic step(input logic t, input logic [3:0] f, input string tag);
      item_t it;
      @(negedge clk);
      tick = t;
      flt  = f;
      if (t) begin
         if (mcnt == P - 1) begin
            mcnt  = 0;
            mcode = resolve(f);
         end else begin
            mcnt = mcnt + 1;
         end
      end
      it.exp = level(mcode, mcnt);
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic run(input int cycles, input logic [3:0] f, input int every, input string tag);
      for (int c = 0; c < cycles; c++) step((c % every) == 0, f, tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (pin !== it.exp) begin
            fails++;
            $display("FAIL %s: pin actual %b expected %b at %0t", it.tag, pin, it.exp, $time);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0] pat [4];
      pat[0] = 4'b0001; pat[1] = 4'b0100; pat[2] = 4'b1000; pat[3] = 4'b0010;

      // R1: pin high during reset, with flags asserted
      flt = 4'b1111;
      #11;
      checks++;
      if (pin !== 1'b1) begin
         fails++;
         $display("FAIL R1: pin actual %b expected 1 in reset", pin);
      end
      @(negedge clk);
      flt   = 4'b0000;
      rst_n = 1'b1;

      run(5, 4'b1111, 1000, "R1");        // single tick then idle: still no boundary
      run(P * 2, 4'b0000, 1, "R2");
      run(P * 3, 4'b0001, 1, "R3");
      run(P * 3, 4'b0010, 1, "R4");
      run(P * 3, 4'b0100, 1, "R5");
      run(P * 3, 4'b1000, 1, "R6");
      run(P * 2, 4'b0011, 1, "R7");
      run(P * 2, 4'b0111, 1, "R7");
      run(P * 2, 4'b1111, 1, "R7");
      run(P * 2, 4'b0101, 1, "R7");
      run(P * 2, 4'b0000, 1, "R2");
      run(P * 3 * 3, 4'b0001, 3, "R8");
      run(P * 2 * 2, 4'b0010, 2, "R8");
      for (int c = 0; c < P * 6; c++) step(1'b1, pat[(c / 7) % 4], "R9");
      for (int c = 0; c < P * 6; c++) step((c % 2) == 0, pat[(c / 5) % 4], "R9");
      run(P * 2, 4'b0000, 1, "R2");

      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule